// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the periodic frame-sync strobe that paces a sampling interface. It divides the master clock by a fixed prescale of 16 and then by three programmable factors, M, N and P. A frame therefore lasts 16 × M × N × P master-clock cycles. The sync output is high for the first 16 cycles of every frame. A one-cycle frame-start pulse marks the falling edge of the sync output, which is where data transfer in both directions begins.

Software loads M, N, P, a filter-bypass flag and the number of cascaded devices through a single write strobe. The written values are staged, and the divider picks them up only at the next frame boundary, so a frame in progress always completes at its old length. A live transfer-mode input selects continuous transfer or programming transfer. A combinational legality check compares the bit slots the staged divide chain provides against the slots the cascade needs in that mode. When there are too few, it raises an error flag. The flag is advisory only, and frame generation carries on.

Top module: `fsync_gen`

## Requirements
- R1: The distance between consecutive frame-start pulses is 16 × M × N × P master-clock cycles, where M is 1..128, N is 1..16 and P is 1..8.
- R2: M is written as a 7-bit field, N as a 4-bit field and P as a 3-bit field. A field value of zero stands for the largest value (M=128, N=16, P=8), and any other value stands for itself.
- R3: While reset is asserted, fsync is 1, frameStart is 0 and cfgErr is 0. Reset loads M=1, N=1, P=8, bypass off and one device, so the first frame is 128 cycles long.
- R4: fsync is high during exactly the first 16 cycles of each frame and low for the rest. With a 16-cycle frame it stays high.
- R5: frameStart is high for one cycle at frame position 16. That is the cycle in which fsync has just fallen. With a 16-cycle frame, the position wraps to 0. The first pulse after reset release comes at the 16th clock edge.
- R6: Values written during a frame take effect at the next frame boundary. The frame in progress is neither shortened nor lengthened.
- R7: With bypass off, cfgErr is 1 exactly when M × N × P < devices × weight.
- R8: With bypass on, cfgErr is 1 exactly when floor(M/4) × N × P < devices × weight.
- R9: The device count is a 3-bit field in which zero stands for 8. The weight is 1 when xferMode is 0 (continuous transfer) and 2 when xferMode is 1 (programming transfer). cfgErr follows xferMode without a write.
- R10: An asserted cfgErr does not stop or change frame generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Write strobe for the staged configuration |
| cfgM | input | 7 | M field (0 encodes 128) |
| cfgN | input | 4 | N field (0 encodes 16) |
| cfgP | input | 3 | P field (0 encodes 8) |
| cfgBypass | input | 1 | Filter bypass flag used by the legality rule |
| cfgDevNum | input | 3 | Cascaded device count (0 encodes 8) |
| xferMode | input | 1 | 0 continuous transfer, 1 programming transfer |
| fsync | output | 1 | Frame sync, high for the first 16 cycles of a frame |
| frameStart | output | 1 | One-cycle pulse on the falling edge of fsync |
| cfgErr | output | 1 | Staged configuration provides too few slots |

## Verification
The hardest case to reach is a write that lands in the middle of a long frame. Only the length of that one frame shows whether the boundary rule holds. The bench first settles a 2560-cycle frame and aligns itself to a frame-start pulse. It then counts 100 cycles, writes a 32-cycle setting, and counts on to the next pulse. That pulse must fall exactly 2560 cycles after the aligning one, and the interval after it must be 32 cycles. The legality rule is swept over every N and P, every device count, both bypass settings, both modes and a spread of M values that includes the floor(M/4) corner values.

// File: rtl/fsync_gen_pkg.sv
package fsync_gen_pkg;

  // Transfer mode selected on the xferMode pin
  typedef enum logic {
    XFER_CONT = 1'b0,
    XFER_PROG = 1'b1
  } xferMode_e;

  // Strobes from the counting datapath to the control
  typedef struct packed {
    logic frameEnd;   // last cycle of the current frame
    logic windowEnd;  // last cycle of a 16-cycle prescale window
  } dpEvents_t;

endpackage

// File: rtl/fsync_gen_ctrl.sv
module fsync_gen_ctrl
  import fsync_gen_pkg::*;
#(
  parameter int M_W   = 7,
  parameter int N_W   = 4,
  parameter int P_W   = 3,
  parameter int DEV_W = 3,
  localparam int MV_W   = M_W + 1,
  localparam int NV_W   = N_W + 1,
  localparam int PV_W   = P_W + 1,
  localparam int DV_W   = DEV_W + 1,
  localparam int PROD_W = MV_W + NV_W + PV_W,
  localparam int NEED_W = DV_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [M_W-1:0]   cfgM,
  input  logic [N_W-1:0]   cfgN,
  input  logic [P_W-1:0]   cfgP,
  input  logic             cfgBypass,
  input  logic [DEV_W-1:0] cfgDevNum,
  input  xferMode_e        xferMode,
  input  dpEvents_t        evt,
  output logic [MV_W-1:0]  mLim,
  output logic [NV_W-1:0]  nLim,
  output logic [PV_W-1:0]  pLim,
  output logic             cfgErr
);

  localparam logic [MV_W-1:0] M_MAX = MV_W'(1 << M_W);
  localparam logic [NV_W-1:0] N_MAX = NV_W'(1 << N_W);
  localparam logic [PV_W-1:0] P_MAX = PV_W'(1 << P_W);
  localparam logic [DV_W-1:0] D_MAX = DV_W'(1 << DEV_W);

  // Staged (software-visible) fields
  logic [M_W-1:0]   mStg;
  logic [N_W-1:0]   nStg;
  logic [P_W-1:0]   pStg;
  logic             bypStg;
  logic [DEV_W-1:0] devStg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mStg   <= M_W'(1);
      nStg   <= N_W'(1);
      pStg   <= '0;          // zero encodes the largest P
      bypStg <= 1'b0;
      devStg <= DEV_W'(1);
    end else if (cfgWr) begin
      mStg   <= cfgM;
      nStg   <= cfgN;
      pStg   <= cfgP;
      bypStg <= cfgBypass;
      devStg <= cfgDevNum;
    end
  end

  // Field decode: zero selects the top of the range
  logic [MV_W-1:0] mDec;
  logic [NV_W-1:0] nDec;
  logic [PV_W-1:0] pDec;
  logic [DV_W-1:0] devDec;

  always_comb begin
    mDec   = (mStg   == '0) ? M_MAX : {1'b0, mStg};
    nDec   = (nStg   == '0) ? N_MAX : {1'b0, nStg};
    pDec   = (pStg   == '0) ? P_MAX : {1'b0, pStg};
    devDec = (devStg == '0) ? D_MAX : {1'b0, devStg};
  end

  // Active divide factors, swapped in only at a frame boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mLim <= MV_W'(1);
      nLim <= NV_W'(1);
      pLim <= P_MAX;
    end else if (evt.frameEnd) begin
      mLim <= mDec;
      nLim <= nDec;
      pLim <= pDec;
    end
  end

  // Slot legality on the staged values
  logic [MV_W-1:0]   mEff;
  logic [PROD_W-1:0] slotCnt;
  logic [NEED_W-1:0] slotNeed;

  always_comb begin
    mEff     = bypStg ? (mDec >> 2) : mDec;
    slotCnt  = PROD_W'(mEff) * PROD_W'(nDec) * PROD_W'(pDec);
    slotNeed = (xferMode == XFER_PROG) ? {devDec, 1'b0} : {1'b0, devDec};
    cfgErr   = slotCnt < PROD_W'(slotNeed);
  end

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evt.frameEnd |=> ($stable(mLim) && $stable(nLim) && $stable(pLim)));

  // R2
  active_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mLim != '0) && (mLim <= M_MAX) && (nLim != '0) && (nLim <= N_MAX)
    && (pLim != '0) && (pLim <= P_MAX));

endmodule

// File: rtl/fsync_gen_datapath.sv
module fsync_gen_datapath
  import fsync_gen_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int MV_W  = 8,
  parameter int NV_W  = 5,
  parameter int PV_W  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [MV_W-1:0] mLim,
  input  logic [NV_W-1:0] nLim,
  input  logic [PV_W-1:0] pLim,
  output logic            fsync,
  output logic            frameStart,
  output dpEvents_t       evt
);

  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] preCnt;
  logic [PV_W-1:0]  pCnt;
  logic [NV_W-1:0]  nCnt;
  logic [MV_W-1:0]  mCnt;
  logic             prevWinFirst;

  logic preWrap, pWrap, nWrap, mWrap;

  always_comb begin
    preWrap = (preCnt == PRE_LAST);
    pWrap   = preWrap && (pCnt == pLim - PV_W'(1));
    nWrap   = pWrap   && (nCnt == nLim - NV_W'(1));
    mWrap   = nWrap   && (mCnt == mLim - MV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      pCnt   <= '0;
      nCnt   <= '0;
      mCnt   <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
      if (pWrap)        pCnt <= '0;
      else if (preWrap) pCnt <= pCnt + PV_W'(1);
      if (nWrap)        nCnt <= '0;
      else if (pWrap)   nCnt <= nCnt + NV_W'(1);
      if (mWrap)        mCnt <= '0;
      else if (nWrap)   mCnt <= mCnt + MV_W'(1);
    end
  end

  // Remember whether the window just finished was the first one of a frame
  always_ff @(posedge clk) begin
    if (!rstN)        prevWinFirst <= 1'b0;
    else if (preWrap) prevWinFirst <= fsync;
  end

  always_comb begin
    fsync         = (pCnt == '0) && (nCnt == '0) && (mCnt == '0);
    frameStart    = prevWinFirst && (preCnt == '0);
    evt.frameEnd  = mWrap;
    evt.windowEnd = preWrap;
  end

  // R4
  fs_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsync && (preCnt != PRE_LAST)) |=> fsync);

  // R4
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.frameEnd |=> fsync);

  // R5
  start_after_fs_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> $past(fsync));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pCnt < pLim) && (nCnt < nLim) && (mCnt < mLim));

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsync_gen_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int M_W   = 7,
  parameter int N_W   = 4,
  parameter int P_W   = 3,
  parameter int DEV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [M_W-1:0]   cfgM,
  input  logic [N_W-1:0]   cfgN,
  input  logic [P_W-1:0]   cfgP,
  input  logic             cfgBypass,
  input  logic [DEV_W-1:0] cfgDevNum,
  input  logic             xferMode,
  output logic             fsync,
  output logic             frameStart,
  output logic             cfgErr
);

  localparam int MV_W = M_W + 1;
  localparam int NV_W = N_W + 1;
  localparam int PV_W = P_W + 1;

  dpEvents_t       evt;
  logic [MV_W-1:0] mLim;
  logic [NV_W-1:0] nLim;
  logic [PV_W-1:0] pLim;

  fsync_gen_ctrl #(
    .M_W(M_W), .N_W(N_W), .P_W(P_W), .DEV_W(DEV_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr),
    .cfgM(cfgM), .cfgN(cfgN), .cfgP(cfgP),
    .cfgBypass(cfgBypass), .cfgDevNum(cfgDevNum),
    .xferMode(xferMode_e'(xferMode)), .evt(evt),
    .mLim(mLim), .nLim(nLim), .pLim(pLim), .cfgErr(cfgErr)
  );

  fsync_gen_datapath #(
    .PRE_W(PRE_W), .MV_W(MV_W), .NV_W(NV_W), .PV_W(PV_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .mLim(mLim), .nLim(nLim), .pLim(pLim),
    .fsync(fsync), .frameStart(frameStart), .evt(evt)
  );

endmodule

// File: tb/sim_fsync_gen.sv
module sim_fsync_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic [6:0] cfgM = '0;
  logic [3:0] cfgN = '0;
  logic [2:0] cfgP = '0;
  logic cfgBypass = 1'b0;
  logic [2:0] cfgDevNum = '0;
  logic xferMode = 1'b0;
  logic fsync, frameStart, cfgErr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_gen u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr),
    .cfgM(cfgM), .cfgN(cfgN), .cfgP(cfgP),
    .cfgBypass(cfgBypass), .cfgDevNum(cfgDevNum), .xferMode(xferMode),
    .fsync(fsync), .frameStart(frameStart), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input int m, input int n, input int p, input int byp, input int dev);
    @(negedge clk);
    cfgM = 7'(m); cfgN = 4'(n); cfgP = 3'(p);
    cfgBypass = byp[0]; cfgDevNum = 3'(dev);
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // Counts negedges up to and including the next frameStart
  task automatic measure(output int cyc, output int hi, output bit fsAtPulse);
    cyc = 0; hi = 0; fsAtPulse = 1'b0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (fsync) hi++;
      if (frameStart) begin
        fsAtPulse = fsync;
        break;
      end
    end
  endtask

  function automatic int decodeF(input int raw, input int maxV);
    return (raw == 0) ? maxV : raw;
  endfunction

  task automatic periodCase(input int m, input int n, input int p, input string tag);
    int c, h, exp;
    bit f;
    exp = 16 * decodeF(m, 128) * decodeF(n, 16) * decodeF(p, 8);
    writeCfg(m, n, p, 0, 1);
    measure(c, h, f);
    measure(c, h, f);
    measure(c, h, f);
    chk(c == exp, tag, c, exp);                       // R1 / R2
    chk(h == 16, "R4 fsync high count", h, 16);       // R4
    chk(f == (exp == 16), "R5 fsync at pulse", int'(f), int'(exp == 16));  // R5
  endtask

  initial begin
    int c, h, c0;
    bit f;
    // R3 reset state
    repeat (3) @(negedge clk);
    chk(fsync == 1'b1, "R3 fsync in reset", int'(fsync), 1);
    chk(frameStart == 1'b0, "R3 frameStart in reset", int'(frameStart), 0);
    chk(cfgErr == 1'b0, "R3 cfgErr in reset", int'(cfgErr), 0);
    rstN = 1'b1;
    // R5 first pulse at edge 16
    measure(c, h, f);
    chk(c == 16, "R5 first pulse", c, 16);
    // R3 default period 128
    measure(c, h, f);
    chk(c == 128, "R3 default period", c, 128);
    chk(h == 16, "R4 default high count", h, 16);

    periodCase(1, 1, 1, "R1 period 1x1x1");
    periodCase(2, 1, 1, "R1 period 2x1x1");
    periodCase(3, 2, 5, "R1 period 3x2x5");
    periodCase(5, 3, 7, "R1 period 5x3x7");
    periodCase(4, 4, 2, "R1 period 4x4x2");
    periodCase(1, 1, 0, "R2 P field zero");
    periodCase(0, 1, 1, "R2 M field zero");
    periodCase(10, 0, 1, "R2 N field zero 10x16x1");

    // R6 mid-frame write keeps the running frame intact
    measure(c, h, f);
    c0 = 0;
    repeat (100) begin @(negedge clk); c0++; end
    writeCfg(2, 1, 1, 0, 1);
    c0 += 2;
    measure(c, h, f);
    chk(c0 + c == 2560, "R6 frame in progress", c0 + c, 2560);
    measure(c, h, f);
    chk(c == 32, "R6 new period after boundary", c, 32);

    // R10 error flag does not stop frames
    writeCfg(1, 1, 1, 1, 1);
    #1;
    chk(cfgErr == 1'b1, "R8 bypass small M", int'(cfgErr), 1);
    measure(c, h, f);
    measure(c, h, f);
    measure(c, h, f);
    chk(c == 16, "R10 frames continue with error", c, 16);
    chk(cfgErr == 1'b1, "R10 flag still set", int'(cfgErr), 1);
    writeCfg(1, 1, 1, 0, 2);
    #1;
    chk(cfgErr == 1'b1, "R7 two devices one slot", int'(cfgErr), 1);
    xferMode = 1'b0;

    // R7 R8 R9 legality sweep
    foreach (mSet[i]) begin
      for (int n = 0; n < 16; n++) begin
        for (int p = 0; p < 8; p++) begin
          for (int byp = 0; byp < 2; byp++) begin
            for (int d = 0; d < 8; d++) begin
              int mv, meff, slots, expE;
              mv = decodeF(mSet[i], 128);
              meff = byp ? mv / 4 : mv;
              slots = meff * decodeF(n, 16) * decodeF(p, 8);
              writeCfg(mSet[i], n, p, byp, d);
              xferMode = 1'b0;
              #1;
              expE = int'(slots < decodeF(d, 8));
              chk(int'(cfgErr) == expE, byp ? "R8 legality mode0" : "R7 legality mode0",
                  int'(cfgErr), expE);
              xferMode = 1'b1;
              #1;
              expE = int'(slots < 2 * decodeF(d, 8));
              chk(int'(cfgErr) == expE, "R9 legality mode1", int'(cfgErr), expE);
              xferMode = 1'b0;
            end
          end
        end
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int mSet[12] = '{0, 1, 2, 3, 4, 5, 7, 8, 11, 16, 63, 127};

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule